// File: doc/BRIEF.md
# Real-Time Clock Update-Cycle Controller

This block keeps calendar time (seconds, minutes, hours, day of month, month, two-digit year) and advances it once per second. The second is counted from a single-cycle `tick` enable that marks each period of a 32.768 kHz time base. A status bit called update-in-progress (`uip`) warns software that the time registers are about to change. It rises `LEAD_TICKS` ticks before the update cycle starts, and it stays high for the `UPD_TICKS` ticks of the update itself. The time registers change on the tick that ends the update. With the default parameters that is 8 ticks of lead (about 244 us) plus 65 ticks of update (about 1984 us).

At the end of every update the block sets an update-ended flag. It compares the new seconds, minutes and hours against three alarm registers and sets an alarm flag on a match. It drives `irq` while any flag is set together with its enable bit. Software reaches everything through a byte-wide register port: an address, write data with a write strobe, and a combinational read-data output with a read strobe. The read strobe only matters for the flag register, where a read clears the flags.

Two other controls stop the clock. A divider-reset bit holds the second counter, and on release the first update starts half a second later. A set bit lets software load the time without an update racing it. The stored time may be in BCD or in binary, and in 24-hour or 12-hour form. The two format bits describe the stored values but never rewrite them.

Top module: `rtc_update_ctrl`

## Requirements
- R1: After reset the registers hold these values: time 00:00:00, day 1 (0x01), month 1 (0x01), year 0x00, all alarms 0x00, control A (address 9) 0x00, control B (address 10) 0x10, flags (address 11) 0x00. The outputs `uip` and `irq` are low.
- R2: While running, `uip` is high for exactly `LEAD_TICKS`+`UPD_TICKS` ticks per second. It falls on the same clock edge at which the time registers take their new value. It is also readable as bit 0 of control A.
- R3: The time advances by one second every `SEC_TICKS` ticks and only on ticks. Seconds carry into minutes at 59, and minutes carry into hours at 59. Counting is BCD when control B bit 3 is 0 and binary when it is 1.
- R4: With control B bit 4 = 0 the hours count in 12-hour form: 1..12, with bit 7 = PM. 11 AM goes to 12 PM (0x92 in BCD), 12 goes to 1, and 11 PM goes to 12 AM (0x12) and carries into the day.
- R5: The day rolls over after the last day of the month. The last day is 30 for months 4, 6, 9 and 11, 31 for the other months, and for month 2 it is 29 if the year is divisible by 4 and 28 otherwise. Month 12 rolls to 1 and carries into the year, and year 99 rolls to 0.
- R6: At each update end flag bit 0 (update-ended) is set. `irq` is high while that flag is set and control B bit 1 (update interrupt enable) is 1.
- R7: At each update end the new seconds, minutes and hours are compared with the alarm registers at addresses 1, 3 and 5. An alarm byte with bits 7:6 = 11 matches any value. A full match sets flag bit 1, and `irq` is high while that flag is set and control B bit 2 is 1.
- R8: The flag register reads {irq, 5'b0, alarm flag, update-ended flag}. A read with `rd_en` clears both flags on that edge, so `irq` is low in the next cycle unless a new update ends on the same edge.
- R9: Control A bit 1 (divider reset) stops updates and `uip`. After it is cleared, `uip` rises `SEC_TICKS`/2-`LEAD_TICKS` ticks later and the first update starts `SEC_TICKS`/2 ticks later.
- R10: While control B bit 0 (set) is 1, no update takes place: `uip` stays low, the time does not change and no flag is set. The divider keeps running.
- R11: Writing control B bits 3 or 4 leaves the stored time registers unchanged. Writes to addresses 0 to 8 store the write data as given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle enable per time-base period |
| addr | input | 4 | Register address (0 to 11) |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (clears the flags when `addr` is 11) |
| rdata | output | 8 | Read data for `addr`, combinational |
| uip | output | 1 | Update in progress |
| irq | output | 1 | Interrupt request |

## Verification
A wrong divider count shows first on `uip`. It would rise or fall a tick early or late, and that shows within one second of running or within half a second of releasing the divider reset. A wrong carry, month length or 12-hour step shows at the port only on the update edge that crosses that boundary, so the bench parks the time one or two seconds before each such boundary. From there, every register visible on `rdata` is compared against the reference model on every clock. A stuck or mis-cleared flag shows on `irq` in the cycle after the update end or after the flag read.

// File: rtl/rtc_update_ctrl.sv
module rtc_update_ctrl #(
  parameter int SEC_TICKS  = 32768,
  parameter int LEAD_TICKS = 8,
  parameter int UPD_TICKS  = 65
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  input  logic       wr_en,
  input  logic       rd_en,
  output logic [7:0] rdata,
  output logic       uip,
  output logic       irq
);
  localparam int DW = $clog2(SEC_TICKS);
  localparam logic [DW-1:0] HOLD_V  = DW'(SEC_TICKS/2 - UPD_TICKS);
  localparam logic [DW-1:0] BUSY_V  = DW'(SEC_TICKS - LEAD_TICKS - UPD_TICKS);
  localparam logic [DW-1:0] LAST_V  = DW'(SEC_TICKS - 1);

  localparam logic [3:0] A_SEC = 4'd0, A_SECAL = 4'd1, A_MIN = 4'd2, A_MINAL = 4'd3,
                         A_HR = 4'd4, A_HRAL = 4'd5, A_DAY = 4'd6, A_MON = 4'd7,
                         A_YR = 4'd8, A_CTLA = 4'd9, A_CTLB = 4'd10, A_FLG = 4'd11;

  logic [DW-1:0] div_q;
  logic [7:0] sec_q, min_q, hr_q, day_q, mon_q, yr_q;
  logic [7:0] secal_q, minal_q, hral_q;
  logic dvrst_q, set_q, uie_q, aie_q, bin_q, h24_q;
  logic uf_q, af_q;

  function automatic logic [7:0] dec(input logic [7:0] v, input logic bin);
    dec = bin ? v : ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
  endfunction

  function automatic logic [7:0] enc(input logic [7:0] b, input logic bin);
    logic [7:0] t, o;
    t = b / 8'd10;
    o = b % 8'd10;
    enc = bin ? b : {t[3:0], o[3:0]};
  endfunction

  function automatic logic hit(input logic [7:0] a, input logic [7:0] v);
    hit = (a[7:6] == 2'b11) || (a == v);
  endfunction

  logic last_tick, upd;
  assign last_tick = tick && (div_q == LAST_V);
  assign upd       = last_tick && !dvrst_q && !set_q;

  logic [7:0] sb, mb, hb, db, mob, yb, dim, h12n;
  logic [7:0] n_sec, n_min, n_hr, n_day, n_mon, n_yr;
  logic c_min, c_hr, c_day, c_mon, c_yr, leap, al_hit;

  always_comb begin
    sb  = dec(sec_q, bin_q);
    mb  = dec(min_q, bin_q);
    db  = dec(day_q, bin_q);
    mob = dec(mon_q, bin_q);
    yb  = dec(yr_q, bin_q);
    hb  = h24_q ? dec(hr_q, bin_q) : dec({1'b0, hr_q[6:0]}, bin_q);

    c_min = sb >= 8'd59;
    n_sec = enc(c_min ? 8'd0 : sb + 8'd1, bin_q);
    c_hr  = c_min && (mb >= 8'd59);
    n_min = c_min ? enc((mb >= 8'd59) ? 8'd0 : mb + 8'd1, bin_q) : min_q;

    if (hb == 8'd11)      h12n = enc(8'd12, bin_q);
    else if (hb >= 8'd12) h12n = enc(8'd1, bin_q);
    else                  h12n = enc(hb + 8'd1, bin_q);

    if (h24_q) begin
      c_day = c_hr && (hb >= 8'd23);
      n_hr  = c_hr ? enc((hb >= 8'd23) ? 8'd0 : hb + 8'd1, bin_q) : hr_q;
    end else begin
      c_day = c_hr && (hb == 8'd11) && hr_q[7];
      n_hr  = c_hr ? {(hb == 8'd11) ? ~hr_q[7] : hr_q[7], h12n[6:0]} : hr_q;
    end

    leap = (yb[1:0] == 2'b00);
    case (mob)
      8'd2:                     dim = leap ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:  dim = 8'd30;
      default:                  dim = 8'd31;
    endcase

    c_mon = c_day && (db >= dim);
    n_day = c_day ? enc((db >= dim) ? 8'd1 : db + 8'd1, bin_q) : day_q;
    c_yr  = c_mon && (mob >= 8'd12);
    n_mon = c_mon ? enc((mob >= 8'd12) ? 8'd1 : mob + 8'd1, bin_q) : mon_q;
    n_yr  = c_yr ? enc((yb >= 8'd99) ? 8'd0 : yb + 8'd1, bin_q) : yr_q;

    al_hit = hit(secal_q, n_sec) && hit(minal_q, n_min) && hit(hral_q, n_hr);
  end

  logic wr_any, rd_flg;
  assign wr_any = wr_en;
  assign rd_flg = rd_en && (addr == A_FLG);

  always_ff @(posedge clk) begin
    if (!rst_n)             div_q <= '0;
    else if (dvrst_q)       div_q <= HOLD_V;
    else if (tick)          div_q <= (div_q == LAST_V) ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q <= 8'h00; min_q <= 8'h00; hr_q <= 8'h00;
      day_q <= 8'h01; mon_q <= 8'h01; yr_q <= 8'h00;
    end else begin
      if (upd) begin
        sec_q <= n_sec; min_q <= n_min; hr_q <= n_hr;
        day_q <= n_day; mon_q <= n_mon; yr_q <= n_yr;
      end
      if (wr_any) begin
        case (addr)
          A_SEC: sec_q <= wdata;
          A_MIN: min_q <= wdata;
          A_HR:  hr_q  <= wdata;
          A_DAY: day_q <= wdata;
          A_MON: mon_q <= wdata;
          A_YR:  yr_q  <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      secal_q <= 8'h00; minal_q <= 8'h00; hral_q <= 8'h00;
      dvrst_q <= 1'b0;
      set_q <= 1'b0; uie_q <= 1'b0; aie_q <= 1'b0; bin_q <= 1'b0; h24_q <= 1'b1;
    end else if (wr_any) begin
      case (addr)
        A_SECAL: secal_q <= wdata;
        A_MINAL: minal_q <= wdata;
        A_HRAL:  hral_q  <= wdata;
        A_CTLA:  dvrst_q <= wdata[1];
        A_CTLB:  {h24_q, bin_q, aie_q, uie_q, set_q} <= wdata[4:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      uf_q <= 1'b0;
      af_q <= 1'b0;
    end else begin
      if (upd)         uf_q <= 1'b1;
      else if (rd_flg) uf_q <= 1'b0;
      if (upd && al_hit) af_q <= 1'b1;
      else if (rd_flg)   af_q <= 1'b0;
    end
  end

  assign uip = !dvrst_q && !set_q && (div_q >= BUSY_V);
  assign irq = (uf_q && uie_q) || (af_q && aie_q);

  always_comb begin
    case (addr)
      A_SEC:   rdata = sec_q;
      A_SECAL: rdata = secal_q;
      A_MIN:   rdata = min_q;
      A_MINAL: rdata = minal_q;
      A_HR:    rdata = hr_q;
      A_HRAL:  rdata = hral_q;
      A_DAY:   rdata = day_q;
      A_MON:   rdata = mon_q;
      A_YR:    rdata = yr_q;
      A_CTLA:  rdata = {6'd0, dvrst_q, uip};
      A_CTLB:  rdata = {3'd0, h24_q, bin_q, aie_q, uie_q, set_q};
      A_FLG:   rdata = {irq, 5'd0, af_q, uf_q};
      default: rdata = 8'h00;
    endcase
  end
endmodule

module rtc_update_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       wr_en,
  input logic       rd_en,
  input logic [3:0] addr,
  input logic       uip,
  input logic       irq,
  input logic       set_q,
  input logic       dvrst_q,
  input logic [7:0] sec_q
);
  assert_uip_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(uip));

  assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(tick) || $past(wr_en)));

  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 4'd11 && !tick && !wr_en) |=> !irq);

  assert_divrst_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dvrst_q && $past(dvrst_q) && !$past(wr_en)) |-> $stable(sec_q));

  assert_set_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (set_q && $past(set_q) && !$past(wr_en)) |-> $stable(sec_q));
endmodule

bind rtc_update_ctrl rtc_update_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .uip(uip), .irq(irq), .set_q(set_q), .dvrst_q(dvrst_q),
  .sec_q(sec_q)
);

// File: tb/sim_rtc_update_ctrl.sv
module sim_rtc_update_ctrl;
  localparam int SEC = 128, LEAD = 4, UPD = 16;

  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0, rd_en = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic uip, irq;
  int errors = 0, checks = 0;
  bit tick_on = 1, done = 0;

  rtc_update_ctrl #(.SEC_TICKS(SEC), .LEAD_TICKS(LEAD), .UPD_TICKS(UPD)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .uip(uip), .irq(irq));

  always #2 clk = ~clk;
  always @(posedge clk) begin #1; tick = tick_on && !tick; end

  int m_sec, m_min, m_hr, m_day, m_mon, m_yr, m_sa, m_ma, m_ha;
  int m_div;
  bit m_dv, m_set, m_uie, m_aie, m_bin, m_h24, m_uf, m_af;

  function automatic int dec(int r);
    return m_bin ? r : (r >> 4) * 10 + (r & 15);
  endfunction
  function automatic int enc(int v);
    return m_bin ? v : ((v / 10) << 4) | (v % 10);
  endfunction
  function automatic int hr24();
    int h12;
    if (m_h24) return dec(m_hr);
    h12 = dec(m_hr & 127);
    return (h12 % 12) + (((m_hr & 128) != 0) ? 12 : 0);
  endfunction
  function automatic int hr_enc(int h);
    int h12;
    if (m_h24) return enc(h);
    h12 = (h % 12 == 0) ? 12 : h % 12;
    return enc(h12) | ((h >= 12) ? 128 : 0);
  endfunction
  function automatic bit m_match(int a, int v);
    return ((a & 192) == 192) || (a == v);
  endfunction
  function automatic bit m_uip();
    return !m_dv && !m_set && (m_div >= SEC - LEAD - UPD);
  endfunction
  function automatic bit m_irq();
    return (m_uf && m_uie) || (m_af && m_aie);
  endfunction
  function automatic int m_read(int a);
    case (a)
      0: return m_sec;  1: return m_sa;  2: return m_min; 3: return m_ma;
      4: return m_hr;   5: return m_ha;  6: return m_day; 7: return m_mon;
      8: return m_yr;
      9: return (m_dv ? 2 : 0) | (m_uip() ? 1 : 0);
      10: return (m_h24 << 4) | (m_bin << 3) | (m_aie << 2) | (m_uie << 1) | m_set;
      11: return (m_irq() << 7) | (m_af << 1) | m_uf;
      default: return 0;
    endcase
  endfunction

  task automatic m_advance();
    int s, mi, h, d, mo, y, dm;
    s = dec(m_sec) + 1; mi = dec(m_min); h = hr24();
    d = dec(m_day); mo = dec(m_mon); y = dec(m_yr);
    if (s == 60) begin
      s = 0; mi++;
      if (mi == 60) begin
        mi = 0; h++;
        if (h == 24) begin
          h = 0; d++;
          if (mo == 2) dm = (y % 4 == 0) ? 29 : 28;
          else if (mo == 4 || mo == 6 || mo == 9 || mo == 11) dm = 30;
          else dm = 31;
          if (d > dm) begin
            d = 1; mo++;
            if (mo == 13) begin mo = 1; y = (y + 1) % 100; end
          end
        end
      end
    end
    m_sec = enc(s); m_min = enc(mi); m_hr = hr_enc(h);
    m_day = enc(d); m_mon = enc(mo); m_yr = enc(y);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sec = 0; m_min = 0; m_hr = 0; m_day = 1; m_mon = 1; m_yr = 0;
      m_sa = 0; m_ma = 0; m_ha = 0; m_div = 0;
      m_dv = 0; m_set = 0; m_uie = 0; m_aie = 0; m_bin = 0; m_h24 = 1;
      m_uf = 0; m_af = 0;
    end else begin
      bit up;
      up = tick && !m_dv && !m_set && (m_div == SEC - 1);
      if (m_dv) m_div = SEC / 2 - UPD;
      else if (tick) m_div = (m_div == SEC - 1) ? 0 : m_div + 1;
      if (rd_en && addr == 11) begin m_uf = 0; m_af = 0; end
      if (up) begin
        m_advance();
        m_uf = 1;
        if (m_match(m_sa, m_sec) && m_match(m_ma, m_min) && m_match(m_ha, m_hr)) m_af = 1;
      end
      if (wr_en) begin
        case (addr)
          0: m_sec = wdata; 1: m_sa = wdata; 2: m_min = wdata; 3: m_ma = wdata;
          4: m_hr = wdata;  5: m_ha = wdata; 6: m_day = wdata; 7: m_mon = wdata;
          8: m_yr = wdata;  9: m_dv = wdata[1];
          10: {m_h24, m_bin, m_aie, m_uie, m_set} = wdata[4:0];
          default: ;
        endcase
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check("R2 uip", uip, m_uip());
    check("R6/R7 irq", irq, m_irq());
    check("R3 rdata", rdata, m_read(addr));
  end

  task automatic wr(int a, int d);
    @(posedge clk); #1; addr = 4'(a); wdata = 8'(d); wr_en = 1;
    @(posedge clk); #1; wr_en = 0;
  endtask
  task automatic rd(int a, output int d);
    @(posedge clk); #1; addr = 4'(a); rd_en = 1;
    @(negedge clk); d = rdata;
    @(posedge clk); #1; rd_en = 0;
  endtask
  task automatic wait_update();
    do @(negedge clk); while (!uip);
    do @(negedge clk); while (uip);
  endtask
  task automatic load(int cb, int h, int mi, int s, int d, int mo, int y);
    wr(10, cb | 1);
    wr(4, h); wr(2, mi); wr(0, s); wr(6, d); wr(7, mo); wr(8, y);
    wr(10, cb);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int v, n;
    repeat (4) @(posedge clk);
    #1; rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(10, v); check("R1 ctrlB", v, 8'h10);
    rd(6, v);  check("R1 day", v, 8'h01);
    rd(11, v); check("R1 flags", v, 0);
    check("R1 uip", uip, 0); check("R1 irq", irq, 0);

    // R2 uip width, R3/R5 full BCD rollover
    load(8'h10, 8'h23, 8'h59, 8'h58, 8'h31, 8'h12, 8'h99);
    do @(negedge clk); while (!uip);
    n = 0;
    while (uip) begin if (tick) n++; @(negedge clk); end
    check("R2 uip ticks", n, LEAD + UPD);
    wait_update();
    rd(0, v); check("R3 sec", v, 8'h00);
    rd(4, v); check("R3 hour", v, 8'h00);
    rd(6, v); check("R5 day", v, 8'h01);
    rd(7, v); check("R5 month", v, 8'h01);
    rd(8, v); check("R5 year", v, 8'h00);

    // R6 update interrupt, R8 flag read
    wr(10, 8'h12);
    rd(11, v);
    wait_update();
    @(negedge clk); check("R6 irq", irq, 1);
    rd(11, v); check("R8 flags", v, 8'h81);
    @(negedge clk); check("R8 irq cleared", irq, 0);

    // R7 alarm with don't-care fields
    wr(10, 8'h11);
    wr(0, 8'h10); wr(1, 8'h12); wr(3, 8'hC0); wr(5, 8'hFF);
    wr(10, 8'h14);
    rd(11, v);
    wait_update();
    rd(11, v); check("R7 no match", v, 8'h01);
    wait_update();
    @(negedge clk); check("R7 irq", irq, 1);
    rd(11, v); check("R7 match", v, 8'h83);

    // R4 12-hour mode
    load(8'h00, 8'h11, 8'h59, 8'h59, 8'h05, 8'h03, 8'h10);
    wait_update();
    rd(4, v); check("R4 11AM->12PM", v, 8'h92);
    load(8'h00, 8'h91, 8'h59, 8'h59, 8'h05, 8'h03, 8'h10);
    wait_update();
    rd(4, v); check("R4 11PM->12AM", v, 8'h12);
    rd(6, v); check("R4 day carry", v, 8'h06);

    // R5 leap years in binary mode
    load(8'h18, 23, 59, 59, 28, 2, 24);
    wait_update();
    rd(6, v); check("R5 leap day", v, 29);
    load(8'h18, 23, 59, 59, 28, 2, 23);
    wait_update();
    rd(6, v); check("R5 plain day", v, 1);
    rd(7, v); check("R5 plain month", v, 3);
    load(8'h18, 23, 59, 59, 30, 4, 23);
    wait_update();
    rd(7, v); check("R5 april end", v, 5);

    // R11 format bits do not convert
    wr(10, 8'h11); wr(0, 8'h25);
    wr(10, 8'h09);
    rd(0, v); check("R11 sec kept", v, 8'h25);
    wr(10, 8'h01);
    rd(0, v); check("R11 sec kept 12h", v, 8'h25);

    // R10 set inhibits
    rd(11, v);
    n = 0;
    repeat (3 * SEC * 2) begin @(negedge clk); if (uip) n++; end
    check("R10 uip never", n, 0);
    rd(0, v); check("R10 sec frozen", v, 8'h25);
    rd(11, v); check("R10 no flag", v, 0);

    // R9 divider reset and half-second first update
    wr(10, 8'h10);
    wr(9, 8'h02);
    repeat (3 * SEC * 2) @(negedge clk);
    rd(0, v); check("R9 sec held", v, 8'h25);
    wr(9, 8'h00);
    n = 0;
    forever begin
      @(negedge clk);
      if (uip || n > SEC) break;
      if (tick) n++;
    end
    check("R9 uip delay", n, SEC / 2 - LEAD);
    wait_update();
    rd(0, v); check("R9 first update", v, 8'h26);

    // R3 tick gating
    tick_on = 0;
    repeat (3 * SEC) @(negedge clk);
    rd(0, v); check("R3 no tick no advance", v, 8'h26);
    tick_on = 1;
    wait_update();
    rd(0, v); check("R3 resumes", v, 8'h27);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule